// File: doc/BRIEF.md
# Per-Output Cell Queue Buffer for a Switch Input

This block sits at one input of an input-queued switch and holds fixed-size cells until the fabric scheduler lets them cross. Every arriving cell names the output it is bound for. The block appends the cell to a queue kept for that output alone. All queues share one cell memory. Storage is handed out from a pool of free slots and chained per queue through a link table.

The block raises one request bit for each output whose queue holds cells. When the scheduler answers with a one-hot grant, the oldest cell of the granted queue appears on the next cycle. A cell that is stuck waiting for a busy output never holds back cells bound for other outputs. When the memory has no free slot left, an arriving cell is dropped and counted. A registered backpressure flag warns the upstream source before the memory runs out, at a level that the user sets.

Top module: `voq_buffer`

## Requirements
- R1: Bit q of `req` is 1 exactly when the queue for output q holds at least one cell. The value is visible in the cycle after the clock edge that changed the queue.
- R2: A grant with exactly one bit set, at bit q, to a queue that is not empty removes that queue's oldest cell. After the next clock edge, `out_valid`=1, `out_port`=q (binary) and `out_cell` holds that cell. In all other cycles `out_valid`=0.
- R3: Cells bound for the same output leave in the order they arrived.
- R4: A cell waiting in an ungranted queue does not delay the dequeue of cells held in other queues.
- R5: The following grants are ignored: a grant with zero bits set, a grant with more than one bit set, and a grant to an empty queue. Such a grant gives no output cell and leaves every queue unchanged.
- R6: An enqueue and a dequeue on the same queue in one cycle keep the queue's count and order correct, including when the queue holds a single cell.
- R7: The buffer has 32 slots shared by all queues. A cell with `in_valid`=1 is admitted if at least one slot is free at the start of the cycle, and dropped otherwise. A slot freed by a dequeue in the same cycle cannot be reused in that cycle. Dropped cells do not disturb stored cells.
- R8: `drop_count` goes up by one for each dropped cell and stays at 16'hFFFF once it gets there.
- R9: After every clock edge, `backpressure` equals (free slots ≤ `bp_level`).
- R10: While `rst` is high and after it is released, all queues are empty. In that state `req`=0, `out_valid`=0, `backpressure`=0 and `drop_count`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An arriving cell is present |
| in_dest | input | 2 | Output index (binary) of the arriving cell |
| in_cell | input | 32 | Arriving cell payload |
| bp_level | input | 6 | Free-slot level at or below which backpressure is raised |
| grant | input | 4 | Scheduler grant, one bit per output |
| req | output | 4 | Per-output request: queue not empty |
| out_valid | output | 1 | A dequeued cell is on `out_cell` |
| out_port | output | 2 | Output index of the dequeued cell |
| out_cell | output | 32 | Dequeued cell payload |
| backpressure | output | 1 | Registered congestion flag toward the source |
| drop_count | output | 16 | Saturating count of dropped cells |

## Verification
The bench places a cell behind a queue that stays ungranted while other queues drain. A design that shared one FIFO would deliver nothing in that window. It dequeues and enqueues on a queue that holds a single cell. If the head pointer were updated wrongly, the next dequeue from that queue would return a stale cell or the wrong count. It sends grants to empty queues and grants with two bits set. An unguarded design would put out invalid cells or corrupt a queue. It fills the memory to the last slot and offers a cell in the same cycle as a dequeue, which shows whether admission wrongly reuses a slot that has just been freed. It checks backpressure on both sides of the threshold. Finally, it pushes the drop counter past its limit, where a counter that wrapped would read a small value.

// File: rtl/voq_pkg.sv
package voq_pkg;
  localparam int unsigned VOQ_PORTS = 4;
  localparam int unsigned VOQ_DEPTH = 32;
  localparam int unsigned VOQ_WIDTH = 32;
  localparam int unsigned VOQ_DROPW = 16;
endpackage

// File: rtl/voq_free_list.sv
module voq_free_list #(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pop,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  output logic [AW-1:0] top_addr,
  output logic [CW-1:0] free_cnt
);
  logic [AW-1:0] slots [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign top_addr = slots[rd_ptr];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) slots[i] <= AW'(i);
      rd_ptr   <= '0;
      wr_ptr   <= '0;
      free_cnt <= CW'(DEPTH);
    end else begin
      if (pop) rd_ptr <= bump(rd_ptr);
      if (push) begin
        slots[wr_ptr] <= push_addr;
        wr_ptr        <= bump(wr_ptr);
      end
      free_cnt <= free_cnt + CW'(push) - CW'(pop);
    end
  end

  // R7: slots are only taken from a non-empty pool and returned to a non-full one
  p_pop_nonempty_r7: assert property (@(posedge clk) disable iff (rst)
    pop |-> (free_cnt != '0));
  p_push_notfull_r7: assert property (@(posedge clk) disable iff (rst)
    push |-> (free_cnt != CW'(DEPTH)));
endmodule

// File: rtl/voq_cell_ram.sv
module voq_cell_ram #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned DEPTH = 32,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/voq_queue_ctl.sv
module voq_queue_ctl #(
  parameter int unsigned PORTS = 4,
  parameter int unsigned DEPTH = 32,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1),
  localparam int unsigned PW = (PORTS > 1) ? $clog2(PORTS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enq,
  input  logic [PW-1:0]    enq_dest,
  input  logic [AW-1:0]    enq_addr,
  input  logic             deq,
  input  logic [PW-1:0]    deq_sel,
  output logic [PORTS-1:0] nonempty,
  output logic [AW-1:0]    deq_addr,
  output logic [CW-1:0]    occupancy
);
  logic [AW-1:0] head [PORTS];
  logic [AW-1:0] tail [PORTS];
  logic [CW-1:0] cnt  [PORTS];
  logic [AW-1:0] link [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int q = 0; q < PORTS; q++) begin
        head[q] <= '0;
        tail[q] <= '0;
        cnt[q]  <= '0;
      end
    end else begin
      for (int q = 0; q < PORTS; q++) begin
        automatic logic hit_e = enq && (enq_dest == PW'(q));
        automatic logic hit_d = deq && (deq_sel == PW'(q));
        cnt[q] <= cnt[q] + CW'(hit_e) - CW'(hit_d);
        if (hit_e) tail[q] <= enq_addr;
        if (hit_e && (cnt[q] == '0 || (hit_d && cnt[q] == CW'(1))))
          head[q] <= enq_addr;
        else if (hit_d)
          head[q] <= link[head[q]];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (enq && cnt[enq_dest] != '0) link[tail[enq_dest]] <= enq_addr;
  end

  generate
    for (genvar g = 0; g < PORTS; g++) begin : g_flag
      assign nonempty[g] = (cnt[g] != '0);
      // R1: a queue never holds more cells than the shared memory has slots
      p_cnt_bound_r1: assert property (@(posedge clk) disable iff (rst)
        cnt[g] <= CW'(DEPTH));
    end
  endgenerate

  assign deq_addr = head[deq_sel];

  always_comb begin
    occupancy = '0;
    for (int q = 0; q < PORTS; q++) occupancy = occupancy + cnt[q];
  end
endmodule

// File: rtl/voq_buffer.sv
module voq_buffer #(
  parameter int unsigned PORTS = voq_pkg::VOQ_PORTS,
  parameter int unsigned DEPTH = voq_pkg::VOQ_DEPTH,
  parameter int unsigned WIDTH = voq_pkg::VOQ_WIDTH,
  parameter int unsigned DROPW = voq_pkg::VOQ_DROPW,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1),
  localparam int unsigned PW = (PORTS > 1) ? $clog2(PORTS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [PW-1:0]    in_dest,
  input  logic [WIDTH-1:0] in_cell,
  input  logic [CW-1:0]    bp_level,
  input  logic [PORTS-1:0] grant,
  output logic [PORTS-1:0] req,
  output logic             out_valid,
  output logic [PW-1:0]    out_port,
  output logic [WIDTH-1:0] out_cell,
  output logic             backpressure,
  output logic [DROPW-1:0] drop_count
);
  logic [CW-1:0] free_cnt, free_next, occupancy;
  logic [AW-1:0] slot_addr, head_addr;
  logic [PW-1:0] grant_idx;
  logic          admit, drop, take;

  assign admit = in_valid && (free_cnt != '0);
  assign drop  = in_valid && (free_cnt == '0);

  always_comb begin
    grant_idx = '0;
    for (int i = 0; i < PORTS; i++) if (grant[i]) grant_idx = PW'(i);
  end

  assign take      = $onehot(grant) && req[grant_idx];
  assign free_next = free_cnt + CW'(take) - CW'(admit);

  voq_free_list #(.DEPTH(DEPTH)) u_free (
    .clk(clk), .rst(rst), .pop(admit), .push(take), .push_addr(head_addr),
    .top_addr(slot_addr), .free_cnt(free_cnt)
  );

  voq_queue_ctl #(.PORTS(PORTS), .DEPTH(DEPTH)) u_qctl (
    .clk(clk), .rst(rst), .enq(admit), .enq_dest(in_dest), .enq_addr(slot_addr),
    .deq(take), .deq_sel(grant_idx), .nonempty(req), .deq_addr(head_addr),
    .occupancy(occupancy)
  );

  voq_cell_ram #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_ram (
    .clk(clk), .we(admit), .waddr(slot_addr), .wdata(in_cell),
    .re(take), .raddr(head_addr), .rdata(out_cell)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      out_port     <= '0;
      backpressure <= 1'b0;
      drop_count   <= '0;
    end else begin
      out_valid    <= take;
      if (take) out_port <= grant_idx;
      backpressure <= (free_next <= bp_level);
      if (drop && drop_count != '1) drop_count <= drop_count + 1'b1;
    end
  end

  // R7: every slot is either free or held by exactly one queue
  p_space_conserved_r7: assert property (@(posedge clk) disable iff (rst)
    (32'(free_cnt) + 32'(occupancy)) == DEPTH);
  // R2: a single grant to a requesting queue yields a cell next cycle
  p_deq_on_grant_r2: assert property (@(posedge clk) disable iff (rst)
    ($onehot(grant) && ((grant & req) != '0)) |=> out_valid);
  // R9: backpressure follows the free level against the threshold
  p_bp_level_r9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (backpressure == (free_cnt <= $past(bp_level))));
  // R8: a saturated drop counter stays saturated
  p_drop_sat_r8: assert property (@(posedge clk) disable iff (rst)
    (drop_count == '1) |=> (drop_count == '1));
endmodule

// File: tb/voq_buffer_tb.sv
module voq_buffer_tb;
  localparam int NV = 14;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [1:0]  in_dest;
  logic [31:0] in_cell;
  logic [5:0]  bp_level;
  logic [3:0]  grant;
  logic [3:0]  req;
  logic        out_valid;
  logic [1:0]  out_port;
  logic [31:0] out_cell;
  logic        backpressure;
  logic [15:0] drop_count;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  voq_buffer u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_dest(in_dest), .in_cell(in_cell),
    .bp_level(bp_level), .grant(grant), .req(req), .out_valid(out_valid),
    .out_port(out_port), .out_cell(out_cell), .backpressure(backpressure),
    .drop_count(drop_count)
  );

  // {en, dest, cell, grant, exp_valid, exp_port, exp_cell, exp_req}
  localparam logic [77:0] VEC [NV] = '{
    {1'b1, 2'd3, 32'hD0, 4'b0000, 1'b0, 2'd0, 32'h0,  4'b1000},  // R1 fill
    {1'b1, 2'd0, 32'hA0, 4'b0000, 1'b0, 2'd0, 32'h0,  4'b1001},
    {1'b1, 2'd1, 32'hB0, 4'b0000, 1'b0, 2'd0, 32'h0,  4'b1011},
    {1'b1, 2'd0, 32'hA1, 4'b0000, 1'b0, 2'd0, 32'h0,  4'b1011},
    {1'b1, 2'd2, 32'hC0, 4'b0001, 1'b1, 2'd0, 32'hA0, 4'b1111},  // R4 q3 waits
    {1'b0, 2'd0, 32'h0,  4'b0010, 1'b1, 2'd1, 32'hB0, 4'b1101},
    {1'b1, 2'd1, 32'hB1, 4'b0010, 1'b0, 2'd0, 32'h0,  4'b1111},  // R5 empty q1
    {1'b0, 2'd0, 32'h0,  4'b0010, 1'b1, 2'd1, 32'hB1, 4'b1101},
    {1'b1, 2'd0, 32'hA2, 4'b0001, 1'b1, 2'd0, 32'hA1, 4'b1101},  // R6 count=1
    {1'b0, 2'd0, 32'h0,  4'b0001, 1'b1, 2'd0, 32'hA2, 4'b1100},  // R3 order
    {1'b0, 2'd0, 32'h0,  4'b0101, 1'b0, 2'd0, 32'h0,  4'b1100},  // R5 two-hot
    {1'b0, 2'd0, 32'h0,  4'b0100, 1'b1, 2'd2, 32'hC0, 4'b1000},
    {1'b0, 2'd0, 32'h0,  4'b0001, 1'b0, 2'd0, 32'h0,  4'b1000},  // R5 empty q0
    {1'b0, 2'd0, 32'h0,  4'b1000, 1'b1, 2'd3, 32'hD0, 4'b0000}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    in_valid = 1'b0;
    grant    = '0;
  endtask

  initial begin
    rst = 1'b1; idle(); in_dest = '0; in_cell = '0; bp_level = 6'd2;
    repeat (3) tick();
    chk(req == 4'b0, "R10 req", 32'(req), 32'h0);
    chk(out_valid == 1'b0, "R10 out_valid", 32'(out_valid), 32'h0);
    chk(backpressure == 1'b0, "R10 backpressure", 32'(backpressure), 32'h0);
    chk(drop_count == 16'h0, "R10 drop_count", 32'(drop_count), 32'h0);
    rst = 1'b0;
    tick();
    chk(backpressure == 1'b0, "R9 idle", 32'(backpressure), 32'h0);

    // table walk: R1 req, R2 dequeue, R3-R6 per row comments
    for (int i = 0; i < NV; i++) begin
      in_valid = VEC[i][77];
      in_dest  = VEC[i][76:75];
      in_cell  = VEC[i][74:43];
      grant    = VEC[i][42:39];
      tick();
      chk(out_valid == VEC[i][38], $sformatf("R2 valid row %0d", i), 32'(out_valid), 32'(VEC[i][38]));
      if (VEC[i][38]) begin
        chk(out_port == VEC[i][37:36], $sformatf("R2 port row %0d", i), 32'(out_port), 32'(VEC[i][37:36]));
        chk(out_cell == VEC[i][35:4], $sformatf("R3 cell row %0d", i), out_cell, VEC[i][35:4]);
      end
      chk(req == VEC[i][3:0], $sformatf("R1 req row %0d", i), 32'(req), 32'(VEC[i][3:0]));
    end
    idle();
    tick();

    // fill every slot; backpressure threshold boundary
    for (int k = 0; k < 32; k++) begin
      in_valid = 1'b1; in_dest = 2'(k % 4); in_cell = 32'h100 + 32'(k);
      tick();
      if (k == 28) chk(backpressure == 1'b0, "R9 free=3", 32'(backpressure), 32'h0);
      if (k == 29) chk(backpressure == 1'b1, "R9 free=2", 32'(backpressure), 32'h1);
    end
    chk(req == 4'b1111, "R1 full", 32'(req), 32'hF);
    chk(drop_count == 16'd0, "R8 none yet", 32'(drop_count), 32'h0);
    repeat (3) tick();
    chk(drop_count == 16'd3, "R7 drop at full", 32'(drop_count), 32'h3);

    // full memory, dequeue and arrival in the same cycle
    in_dest = 2'd1; in_cell = 32'hDEAD; grant = 4'b0001;
    tick();
    chk(out_valid && out_cell == 32'h100, "R7 deq at full", out_cell, 32'h100);
    chk(drop_count == 16'd4, "R7 no same-cycle reuse", 32'(drop_count), 32'h4);
    chk(backpressure == 1'b1, "R9 free=1", 32'(backpressure), 32'h1);
    idle();

    // drain in per-queue order
    for (int q = 0; q < 4; q++) begin
      for (int j = (q == 0) ? 1 : 0; j < 8; j++) begin
        grant = 4'(1 << q);
        tick();
        chk(out_valid && out_port == 2'(q) && out_cell == 32'h100 + 32'(q + 4 * j),
            "R3 drain order", out_cell, 32'h100 + 32'(q + 4 * j));
      end
    end
    idle();
    tick();
    chk(req == 4'b0, "R1 drained", 32'(req), 32'h0);
    chk(backpressure == 1'b0, "R9 drained", 32'(backpressure), 32'h0);
    chk(out_valid == 1'b0, "R2 idle", 32'(out_valid), 32'h0);

    // refill then saturate the drop counter
    for (int k = 0; k < 32; k++) begin
      in_valid = 1'b1; in_dest = 2'd2; in_cell = 32'h200 + 32'(k);
      tick();
    end
    in_cell = 32'hBAD;
    repeat (65600) tick();
    chk(drop_count == 16'hFFFF, "R8 saturate", 32'(drop_count), 32'hFFFF);
    idle();
    grant = 4'b0100;
    tick();
    chk(out_valid && out_cell == 32'h200, "R7 stored cell intact", out_cell, 32'h200);
    idle();
    tick();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R10 watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule